// File: doc/BRIEF.md
# Connector Loopback Continuity Tester

This block sits in the carrier FPGA and checks the wiring of a connector when a passive test board is plugged into it. The test board shorts connector lines together in fixed pairs. Each pair joins a line to the line two positions above it, and the two clock lanes are joined positive leg to negative leg. A start strobe launches the test. For every step the tester enables exactly one side of every pair, drives a walking pattern, waits a settle time, samples the far side of every pair through a two-flop synchronizer and compares each sample with the value it should see.

The test has 56 steps. There are two passes: a walking one, then a walking zero with every level inverted. In each pass the active pair advances from the lowest to the highest. For each pair the lower-numbered line drives first and the higher-numbered line drives second. Only one pair carries the odd level in any step, so a bridge between two pairs, a stuck line or an open pair makes the affected pairs fail. When the test ends the block presents one pass bit per pair and a global pass flag.

Line numbering: bits 0 to 27 are connector signals 0 to 27. Bits 28 and 29 are the forwarded clock positive and negative legs. Bits 30 and 31 are the return clock positive and negative legs.

Top module: `loop_continuity_tester`

## Requirements
- R1: Pair k joins line L(k) and line H(k). L = 1,5,8,9,12,13,16,17,20,21,24,25,28,30 for k = 0..13. H = L+2 for k < 12 and H = L+1 for k = 12 and 13. During a run, line_oe has exactly one bit set in each pair and no bit set on lines 0, 2, 4 and 6. The values on those four inputs have no effect on any result.
- R2: While busy is low, line_oe is all zero.
- R3: In the walking-one pass, the driving line of the active pair outputs 1 and every other driving line outputs 0. The expected value on a pair's receiving line is 1 for the active pair and 0 for all others.
- R4: In the walking-zero pass, every level of R3 is inverted.
- R5: Step s (0..55) has pass = s/28 (0 means walking one), active pair = (s mod 28)/2, and direction = s mod 2. Direction 0 means L drives and H receives. Direction 1 means H drives and L receives.
- R6: Each step lasts S cycles. S = settle_len, except that a value of 0 selects 16 and values of 1 or 2 are raised to 3. busy rises on the cycle after start is accepted and stays high for exactly 56*S cycles.
- R7: Bit k of pair_ok is 1 only when every sample of pair k's receiving line over the run matched its expected value. all_pass is the AND of all pair_ok bits.
- R8: pair_ok is zero after reset. It is updated only at the end of a run and holds its old value while a run is in progress.
- R9: done is a one-cycle pulse, high in the first cycle after busy falls.
- R10: start has no effect while busy is high. The run length and step order are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, sampled while idle |
| settle_len | input | 8 | Step length in cycles (0 selects 16, minimum 3) |
| line_in | input | 32 | Levels read back from the connector lines |
| line_oe | output | 32 | Per-line output enable |
| line_out | output | 32 | Per-line drive level |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pair_ok | output | 14 | Per-pair pass result of the last run |
| all_pass | output | 1 | All pairs passed |

## Verification
A start accepted at one edge makes busy and the step-0 drive pattern appear right after that edge. Step s then occupies the cycles numbered s*S to s*S+S-1, counted from that edge. The bench counts cycles from that edge and compares line_oe and line_out on every falling edge against the step that cycle number selects. The last sample is taken on edge 56*S. pair_ok, all_pass and the done pulse are therefore read on the first falling edge at which busy is low, and done is read as low again one cycle later. Each result is checked only in the cycle in which it is due.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int NUM_LINES = 32;
  localparam int NUM_PAIRS = 14;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int PAIR_W    = $clog2(NUM_PAIRS);

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  // Lower line of each looped pair: two groups of two-apart links
  // followed by the two clock lanes.
  function automatic int pair_lo(int p);
    if (p < 2)       return 1 + 4 * p;
    else if (p < 12) return 8 + 4 * ((p - 2) / 2) + ((p - 2) % 2);
    else             return 28 + 2 * (p - 12);
  endfunction

  function automatic int pair_hi(int p);
    return (p < 12) ? pair_lo(p) + 2 : pair_lo(p) + 1;
  endfunction
endpackage

// File: rtl/lct_sync.sv
module lct_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/lct_step_seq.sv
module lct_step_seq
  import lct_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SETTLE_DEF = 16,
  parameter int SETTLE_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  settle_len,
  output logic              run,
  output logic              launch,
  output logic              sample,
  output logic              finish,
  output logic              pol,
  output logic              dir,
  output logic [PAIR_W-1:0] pair_idx
);
  localparam logic [CNT_W-1:0]  DEF_C     = CNT_W'(SETTLE_DEF);
  localparam logic [CNT_W-1:0]  MIN_C     = CNT_W'(SETTLE_MIN);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_PAIRS - 1);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PAIR_W-1:0] pair_q, pair_d;
  logic              pol_q, pol_d;
  logic              dir_q, dir_d;
  logic [CNT_W-1:0]  eff_len;
  logic [CNT_W-1:0]  reload;
  logic              last_step;

  always_comb begin
    if (settle_len == '0)        eff_len = DEF_C;
    else if (settle_len < MIN_C) eff_len = MIN_C;
    else                         eff_len = settle_len;
    reload = eff_len - CNT_W'(1);
  end

  assign last_step = pol_q & dir_q & (pair_q == LAST_PAIR);
  assign run       = (state_q == ST_RUN);
  assign launch    = (state_q == ST_IDLE) & start;
  assign sample    = run & (cnt_q == '0);
  assign finish    = sample & last_step;
  assign pol       = pol_q;
  assign dir       = dir_q;
  assign pair_idx  = pair_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pair_d  = pair_q;
    pol_d   = pol_q;
    dir_d   = dir_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = reload;
          pair_d  = '0;
          pol_d   = 1'b0;
          dir_d   = 1'b0;
        end
      end
      default: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (last_step) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = reload;
          dir_d = ~dir_q;
          if (dir_q) begin
            if (pair_q == LAST_PAIR) begin
              pair_d = '0;
              pol_d  = 1'b1;
            end else begin
              pair_d = pair_q + PAIR_W'(1);
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pair_q  <= '0;
      pol_q   <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pair_q  <= pair_d;
      pol_q   <= pol_d;
      dir_q   <= dir_d;
    end
  end

  // R6: within a step the counter only moves down by one
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R5: the lower-line step of a pair is followed by the upper-line step of the same pair
  a_r5_dir_order: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !dir_q) |=> (dir_q && $stable(pair_q) && $stable(pol_q)));

  // R10: a strobe during a step neither restarts nor moves the sequence
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !sample) |=> (run && $stable({pol_q, pair_q, dir_q})));
endmodule

// File: rtl/lct_pattern.sv
module lct_pattern
  import lct_pkg::*;
(
  input  logic                 run,
  input  logic                 pol,
  input  logic                 dir,
  input  logic [PAIR_W-1:0]    pair_idx,
  output logic [NUM_LINES-1:0] line_oe,
  output logic [NUM_LINES-1:0] line_out
);
  always_comb begin
    line_oe  = '0;
    line_out = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      line_oe[LINE_W'(dir ? pair_hi(p) : pair_lo(p))]  = run;
      line_out[LINE_W'(dir ? pair_hi(p) : pair_lo(p))] =
        run & ((PAIR_W'(p) == pair_idx) ^ pol);
    end
  end
endmodule

// File: rtl/lct_check.sv
module lct_check
  import lct_pkg::*;
(
  input  logic                 sample,
  input  logic                 pol,
  input  logic                 dir,
  input  logic [PAIR_W-1:0]    pair_idx,
  input  logic [NUM_LINES-1:0] line_sync,
  output logic [NUM_PAIRS-1:0] mismatch
);
  logic unused_lines;

  always_comb begin
    mismatch     = '0;
    unused_lines = ^line_sync;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      mismatch[p] = sample &
        ((dir ? line_sync[LINE_W'(pair_lo(p))] : line_sync[LINE_W'(pair_hi(p))]) ^
         ((PAIR_W'(p) == pair_idx) ^ pol));
    end
  end
endmodule

// File: rtl/loop_continuity_tester.sv
module loop_continuity_tester
  import lct_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SETTLE_DEF = 16,
  parameter int SETTLE_MIN = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNT_W-1:0]     settle_len,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_LINES-1:0] line_oe,
  output logic [NUM_LINES-1:0] line_out,
  output logic                 busy,
  output logic                 done,
  output logic [NUM_PAIRS-1:0] pair_ok,
  output logic                 all_pass
);
  logic                 rst_meta_q, rst_int_n;
  logic                 run, launch, sample, finish, pol, dir;
  logic [PAIR_W-1:0]    pair_idx;
  logic [NUM_LINES-1:0] line_sync;
  logic [NUM_PAIRS-1:0] mismatch;
  logic [NUM_PAIRS-1:0] fail_q, fail_d;
  logic [NUM_PAIRS-1:0] ok_q, ok_d;
  logic                 done_q, done_d;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  lct_step_seq #(
    .CNT_W(CNT_W), .SETTLE_DEF(SETTLE_DEF), .SETTLE_MIN(SETTLE_MIN)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .settle_len(settle_len),
    .run(run), .launch(launch), .sample(sample), .finish(finish),
    .pol(pol), .dir(dir), .pair_idx(pair_idx)
  );

  lct_pattern u_pat (
    .run(run), .pol(pol), .dir(dir), .pair_idx(pair_idx),
    .line_oe(line_oe), .line_out(line_out)
  );

  lct_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(line_in), .q(line_sync)
  );

  lct_check u_chk (
    .sample(sample), .pol(pol), .dir(dir), .pair_idx(pair_idx),
    .line_sync(line_sync), .mismatch(mismatch)
  );

  always_comb begin
    fail_d = launch ? '0 : (fail_q | mismatch);
    ok_d   = finish ? ~(fail_q | mismatch) : ok_q;
    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fail_q <= '0;
      ok_q   <= '0;
      done_q <= 1'b0;
    end else begin
      fail_q <= fail_d;
      ok_q   <= ok_d;
      done_q <= done_d;
    end
  end

  assign busy     = run;
  assign done     = done_q;
  assign pair_ok  = ok_q;
  assign all_pass = &ok_q;

  // R1: one side of each pair drives while busy, never both
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
    localparam int LO = pair_lo(p);
    localparam int HI = pair_hi(p);
    a_r1_one_side: assert property (@(posedge clk) disable iff (!rst_int_n)
      busy |-> (line_oe[LO] ^ line_oe[HI]));
  end

  // R2: everything tristated while idle
  a_r2_idle_tristate: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (line_oe == '0));

  // R3: walking-one pass has a single high driver
  a_r3_single_high: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && !pol) |-> ($countones(line_out & line_oe) == 1));

  // R4: walking-zero pass has a single low driver
  a_r4_single_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && pol) |-> ($countones(~line_out & line_oe) == 1));

  // R8: results change only on the completion edge
  a_r8_results_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    !done |-> $stable(pair_ok));

  // R9: done is a single-cycle pulse seen with busy low
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !busy);
endmodule

// File: tb/tb_loop_continuity_tester.sv
module tb_loop_continuity_tester;
  localparam int NL    = 32;
  localparam int NP    = 14;
  localparam int STEPS = 56;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    settle_len = 8'd0;
  logic [NL-1:0] line_in;
  logic [NL-1:0] line_oe, line_out;
  logic          busy, done, all_pass;
  logic [NP-1:0] pair_ok;

  int n_checks = 0;
  int n_fail   = 0;

  // fault model: 0 none, 1 stuck low, 2 stuck high, 3 open
  int fkind [NP];
  int br_a = -1;
  int br_b = -1;
  logic          unpaired_lvl = 1'b1;
  logic [NP-1:0] net_v;

  int cur_s   = 16;
  int mon_c   = 0;
  int mon_err = 0;

  always #2 clk = ~clk;

  loop_continuity_tester dut (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_len(settle_len),
    .line_in(line_in), .line_oe(line_oe), .line_out(line_out),
    .busy(busy), .done(done), .pair_ok(pair_ok), .all_pass(all_pass)
  );

  function automatic int blo(int q);
    int tab [NP] = '{1, 5, 8, 9, 12, 13, 16, 17, 20, 21, 24, 25, 28, 30};
    return tab[q];
  endfunction

  function automatic int bhi(int q);
    return (q < 12) ? blo(q) + 2 : blo(q) + 1;
  endfunction

  // passive board model with injected faults
  always_comb begin
    for (int q = 0; q < NP; q++) begin
      if (line_oe[blo(q)])      net_v[q] = line_out[blo(q)];
      else if (line_oe[bhi(q)]) net_v[q] = line_out[bhi(q)];
      else                      net_v[q] = 1'b0;
      if (fkind[q] == 1) net_v[q] = 1'b0;
      if (fkind[q] == 2) net_v[q] = 1'b1;
    end
    if (br_a >= 0 && br_b >= 0) begin
      net_v[br_a] = net_v[br_a] | net_v[br_b];
      net_v[br_b] = net_v[br_a];
    end
  end

  always_comb begin
    line_in = {NL{unpaired_lvl}};
    for (int q = 0; q < NP; q++) begin
      if (fkind[q] == 3) begin
        line_in[blo(q)] = line_oe[blo(q)] & line_out[blo(q)];
        line_in[bhi(q)] = line_oe[bhi(q)] & line_out[bhi(q)];
      end else begin
        line_in[blo(q)] = net_v[q];
        line_in[bhi(q)] = net_v[q];
      end
    end
  end

  // drive-pattern monitor for R1..R5: cycle c of a run belongs to step c/S
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        int s, pol, act, dr;
        logic [NL-1:0] eoe, eout;
        s   = mon_c / cur_s;
        pol = s / 28;
        act = (s % 28) / 2;
        dr  = s % 2;
        eoe = '0;
        eout = '0;
        for (int q = 0; q < NP; q++) begin
          int ln;
          ln = (dr == 1) ? bhi(q) : blo(q);
          eoe[ln]  = 1'b1;
          eout[ln] = ((q == act) ? 1'b1 : 1'b0) ^ pol[0];
        end
        if (line_oe !== eoe || (line_out & line_oe) !== eout) mon_err++;
        mon_c++;
      end else begin
        if (line_oe !== '0) mon_err++;
        mon_c = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int q = 0; q < NP; q++) fkind[q] = 0;
    br_a = -1;
    br_b = -1;
  endtask

  task automatic run_test(input logic [7:0] sl, input int s_eff,
                          input logic [NP-1:0] exp_ok, input int poke_at,
                          input string tag);
    int cycles;
    logic [NP-1:0] prev_ok;
    prev_ok = pair_ok;
    cur_s   = s_eff;
    mon_err = 0;
    @(negedge clk);
    settle_len = sl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (busy) begin
      cycles++;
      if (cycles == 2) chk(pair_ok === prev_ok, "R8", {tag, " held during run"}, pair_ok, prev_ok);
      start = (cycles == poke_at);
      @(negedge clk);
    end
    start = 1'b0;
    chk(cycles == STEPS * s_eff, "R6", {tag, " busy length"}, cycles, STEPS * s_eff);
    chk(done === 1'b1, "R9", {tag, " done rises"}, done, 1);
    chk(pair_ok === exp_ok, "R7", {tag, " pair_ok"}, pair_ok, exp_ok);
    chk(all_pass === (exp_ok == '1), "R7", {tag, " all_pass"}, all_pass, (exp_ok == '1));
    chk(mon_err == 0, "R5", {tag, " drive pattern R1 R2 R3 R4"}, mon_err, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", {tag, " done falls"}, done, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    clear_faults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(busy === 1'b0, "R2", "reset busy", busy, 0);
    chk(line_oe === '0, "R2", "reset oe", line_oe, 0);
    chk(done === 1'b0, "R9", "reset done", done, 0);
    chk(pair_ok === '0, "R8", "reset pair_ok", pair_ok, 0);
    chk(all_pass === 1'b0, "R7", "reset all_pass", all_pass, 0);

    // clean board, several settle settings
    run_test(8'd0, 16, '1, -1, "default settle");
    run_test(8'd5, 5, '1, -1, "settle 5");
    run_test(8'd1, 3, '1, -1, "settle 1 clamp");
    run_test(8'd2, 3, '1, -1, "settle 2 clamp");

    // R1: unpaired inputs low instead of high
    unpaired_lvl = 1'b0;
    run_test(8'd3, 3, '1, -1, "R1 unpaired low");
    unpaired_lvl = 1'b1;

    // R10: extra strobe in the middle of a run
    run_test(8'd4, 4, '1, 100, "R10 restart poke");

    // sweep stuck faults over every pair
    for (int q = 0; q < NP; q++) begin
      for (int k = 1; k <= 2; k++) begin
        clear_faults();
        fkind[q] = k;
        run_test(8'd3, 3, ~(NP'(1) << q), -1, (k == 1) ? "R3 stuck low" : "R4 stuck high");
      end
    end

    // open pairs
    clear_faults();
    fkind[7] = 3;
    run_test(8'd3, 3, ~(NP'(1) << 7), -1, "R7 open pair 7");
    clear_faults();
    fkind[13] = 3;
    run_test(8'd3, 3, ~(NP'(1) << 13), -1, "R7 open pair 13");

    // bridges between pairs
    clear_faults();
    br_a = 0;
    br_b = 1;
    run_test(8'd3, 3, ~((NP'(1) << 0) | (NP'(1) << 1)), -1, "R3 bridge 0-1");
    clear_faults();
    br_a = 11;
    br_b = 12;
    run_test(8'd6, 6, ~((NP'(1) << 11) | (NP'(1) << 12)), -1, "R4 bridge 11-12");

    // recovery on a clean board
    clear_faults();
    run_test(8'd3, 3, '1, -1, "R7 clean again");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule